// File: doc/BRIEF.md
# Flash Page-Buffer Byte Scan Register

This block is a test-port data register for filling a word-wide flash page buffer one byte at a time and for reading flash contents back the same way. A host shifts a byte into an 8-bit chain. Each update then hands that byte to an internal sequencer. The sequencer drives the address, data, byte lane and write strobe toward the page buffer, and waits for the buffer's acknowledge. The host never handles addresses or control lines. It only moves data bytes.

Two mode selects pick the job. In load mode, each update writes one byte. The block alternates between the low and high halves of each 16-bit word, and it advances the word counter itself. The counter is stepped before every low byte except the first. So the first byte lands on the preset word, and the final high byte of a page leaves the counter on the page's last word. In read mode, each capture fetches one half of the addressed word into the chain, low half first. The counter steps after every high half.

Top module: `flash_word_dr`

## Requirements
- R1: During shift, the chain moves one bit per rising clock edge from `tdi_i` toward bit 0 (LSB first). `tdo_o` copies chain bit 0 on the falling edge, so a change made at a rising edge is not visible on `tdo_o` until the following falling edge.
- R2: The first cycle a mode select is seen high (load has priority over read) is the entry cycle. On entry the block loads the word counter from `addr_preset_i`, selects the low byte next, re-arms the first-byte flag and clears the overrun flag.
- R3: In load mode, an update while idle copies the chain into a holding register and starts a write. The cycle after the update is a setup cycle with `busy_o` high and `fl_wr_o` low. `fl_wdata_o`, `fl_hi_o` and `fl_addr_o` stay stable until the write ends.
- R4: Load-mode writes alternate lanes, starting with the low lane after entry. `fl_hi_o`=0 selects word bits [7:0] and `fl_hi_o`=1 selects bits [15:8].
- R5: The word counter (`fl_addr_o`) is incremented before each low-lane write, except the first write after entry. After the last high byte of a run of N words from preset P, the counter reads P+N-1.
- R6: `busy_o` is high from the cycle after the update until the cycle after `fl_ack_i` is sampled with `fl_wr_o` high. With an acknowledge latency of up to 9 strobe cycles, the whole write sequence takes at most 11 clock cycles.
- R7: A load-mode update that arrives while `busy_o` is high changes no counter, lane or data and starts no write. It sets `ovr_o`, which stays high until the next mode entry.
- R8: In read mode, each capture loads the chain with one half of `fl_rdata_i` (the word at `fl_addr_o`). The halves alternate, low ([7:0]) first. The counter advances by one after each high-half capture.
- R9: With neither mode selected, updates start no write and leave `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_mode_i | input | 1 | Page-load mode select |
| read_mode_i | input | 1 | Page-read mode select |
| addr_preset_i | input | AW | Word address loaded on mode entry |
| capture_dr_i | input | 1 | Capture state strobe |
| shift_dr_i | input | 1 | Shift state strobe |
| update_dr_i | input | 1 | Update state strobe |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, falling-edge timed |
| fl_addr_o | output | AW | Page-buffer word address |
| fl_wdata_o | output | 8 | Byte being written |
| fl_hi_o | output | 1 | Lane select, 1 = high byte |
| fl_wr_o | output | 1 | Write strobe, held until acknowledge |
| fl_ack_i | input | 1 | Page-buffer write acknowledge |
| fl_rdata_i | input | 16 | Word at `fl_addr_o` |
| busy_o | output | 1 | Write sequence in progress |
| ovr_o | output | 1 | Sticky update-while-busy flag |

## Verification
The bench loads a whole page of bytes and then checks four things. Every byte must sit in its own lane of its own word. The counter must never step past the last word. A design that incremented the counter after each high byte instead of before each low byte would leave the counter on the next page. A design that also incremented before the first byte would shift the whole page up one word. On re-entry, the bench loads the first byte after leaving the lane toggle on the high side, which exposes a toggle that survives mode changes. A second update sent inside a write window must leave the next word untouched and raise the overrun flag. The bench also reads `tdo_o` on both sides of a falling edge, so output timed on the rising edge is caught.

// File: rtl/flash_dr_pkg.sv
package flash_dr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 2 * BYTE_W;

  typedef enum logic [1:0] {
    WS_IDLE,
    WS_SETUP,
    WS_STROBE
  } wseq_state_e;
endpackage

// File: rtl/flash_dr_shift.sv
module flash_dr_shift #(
  parameter int unsigned W = 8
) (
  input  logic           tck_i,
  input  logic           rst_ni,
  input  logic           shift_i,
  input  logic           tdi_i,
  input  logic           cap_i,
  input  logic           cap_hi_i,
  input  logic [2*W-1:0] rdata_i,
  output logic [W-1:0]   chain_o,
  output logic           tdo_o
);
  logic [W-1:0] chain_q;
  logic         tdo_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)      chain_q <= '0;
    else if (cap_i)   chain_q <= cap_hi_i ? rdata_i[2*W-1:W] : rdata_i[W-1:0];
    else if (shift_i) chain_q <= {tdi_i, chain_q[W-1:1]};
  end

  // output retimed to the falling edge
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) tdo_q <= 1'b0;
    else         tdo_q <= chain_q[0];
  end

  assign chain_o = chain_q;
  assign tdo_o   = tdo_q;

  AST_SHIFT_LSB: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (shift_i && !cap_i) |=> (chain_q[W-2:0] == $past(chain_q[W-1:1]))); // R1
endmodule

// File: rtl/flash_dr_ptr.sv
module flash_dr_ptr #(
  parameter int unsigned AW = 6
) (
  input  logic          tck_i,
  input  logic          rst_ni,
  input  logic          load_mode_i,
  input  logic          read_mode_i,
  input  logic [AW-1:0] preset_i,
  input  logic          update_i,
  input  logic          capture_i,
  input  logic          busy_i,
  output logic [AW-1:0] pc_o,
  output logic          hi_sel_o,
  output logic          start_o,
  output logic          cap_o,
  output logic          ovr_o
);
  logic          load_act, read_act, enter;
  logic          load_q, read_q;
  logic [AW-1:0] pc_q;
  logic          hi_q, first_q, ovr_q;

  assign load_act = load_mode_i;
  assign read_act = read_mode_i & ~load_mode_i;
  assign enter    = (load_act & ~load_q) | (read_act & ~read_q);
  assign start_o  = load_act & update_i & ~busy_i & ~enter;
  assign cap_o    = read_act & capture_i & ~enter;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= 1'b0;
      read_q <= 1'b0;
    end else begin
      load_q <= load_act;
      read_q <= read_act;
    end
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      hi_q    <= 1'b0;
      first_q <= 1'b1;
      ovr_q   <= 1'b0;
    end else if (enter) begin
      pc_q    <= preset_i;
      hi_q    <= 1'b0;
      first_q <= 1'b1;
      ovr_q   <= 1'b0;
    end else if (start_o) begin
      // pre-increment ahead of every low byte but the first
      if (!hi_q && !first_q) pc_q <= pc_q + 1'b1;
      hi_q    <= ~hi_q;
      first_q <= 1'b0;
    end else if (load_act && update_i && busy_i) begin
      ovr_q <= 1'b1;
    end else if (cap_o) begin
      hi_q <= ~hi_q;
      if (hi_q) pc_q <= pc_q + 1'b1;
    end
  end

  assign pc_o     = pc_q;
  assign hi_sel_o = hi_q;
  assign ovr_o    = ovr_q;

  AST_LANE_TOGGLE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    start_o |=> (hi_q != $past(hi_q))); // R4
  AST_PC_HOLD_BUSY: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (busy_i && load_act && !enter) |=> (pc_q == $past(pc_q))); // R5
  AST_OVR_SET: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (load_act && update_i && busy_i && !enter) |=> ovr_q); // R7
  AST_RD_ADVANCE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (cap_o && hi_q) |=> (pc_q == AW'($past(pc_q) + 1'b1))); // R8
endmodule

// File: rtl/flash_dr_wseq.sv
module flash_dr_wseq
  import flash_dr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         tck_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] data_i,
  input  logic         hi_i,
  input  logic         ack_i,
  output logic         busy_o,
  output logic         wr_o,
  output logic [W-1:0] wdata_o,
  output logic         hi_o
);
  wseq_state_e  state_q, state_d;
  logic [W-1:0] hold_q;
  logic         hi_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WS_IDLE:   if (start_i) state_d = WS_SETUP;
      WS_SETUP:  state_d = WS_STROBE;
      WS_STROBE: if (ack_i) state_d = WS_IDLE;
      default:   state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WS_IDLE;
      hold_q  <= '0;
      hi_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_i && state_q == WS_IDLE) begin
        hold_q <= data_i;
        hi_q   <= hi_i;
      end
    end
  end

  assign busy_o  = (state_q != WS_IDLE);
  assign wr_o    = (state_q == WS_STROBE);
  assign wdata_o = hold_q;
  assign hi_o    = hi_q;

  AST_SETUP_FIRST: assert property (@(posedge tck_i) disable iff (!rst_ni)
    start_i |=> (busy_o && !wr_o)); // R3
  AST_STROBE_NEXT: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == WS_SETUP) |=> wr_o); // R6
  AST_WDATA_STABLE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (busy_o && !start_i) |=> ($stable(wdata_o) && $stable(hi_o))); // R3
endmodule

// File: rtl/flash_word_dr.sv
module flash_word_dr
  import flash_dr_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              load_mode_i,
  input  logic              read_mode_i,
  input  logic [AW-1:0]     addr_preset_i,
  input  logic              capture_dr_i,
  input  logic              shift_dr_i,
  input  logic              update_dr_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  output logic [AW-1:0]     fl_addr_o,
  output logic [BYTE_W-1:0] fl_wdata_o,
  output logic              fl_hi_o,
  output logic              fl_wr_o,
  input  logic              fl_ack_i,
  input  logic [WORD_W-1:0] fl_rdata_i,
  output logic              busy_o,
  output logic              ovr_o
);
  logic [BYTE_W-1:0] chain;
  logic              hi_sel, start, cap, busy;

  flash_dr_ptr #(.AW(AW)) i_ptr (
    .tck_i       (tck_i),
    .rst_ni      (rst_ni),
    .load_mode_i (load_mode_i),
    .read_mode_i (read_mode_i),
    .preset_i    (addr_preset_i),
    .update_i    (update_dr_i),
    .capture_i   (capture_dr_i),
    .busy_i      (busy),
    .pc_o        (fl_addr_o),
    .hi_sel_o    (hi_sel),
    .start_o     (start),
    .cap_o       (cap),
    .ovr_o       (ovr_o)
  );

  flash_dr_shift #(.W(BYTE_W)) i_shift (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .shift_i  (shift_dr_i),
    .tdi_i    (tdi_i),
    .cap_i    (cap),
    .cap_hi_i (hi_sel),
    .rdata_i  (fl_rdata_i),
    .chain_o  (chain),
    .tdo_o    (tdo_o)
  );

  flash_dr_wseq #(.W(BYTE_W)) i_wseq (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .data_i  (chain),
    .hi_i    (hi_sel),
    .ack_i   (fl_ack_i),
    .busy_o  (busy),
    .wr_o    (fl_wr_o),
    .wdata_o (fl_wdata_o),
    .hi_o    (fl_hi_o)
  );

  assign busy_o = busy;

  AST_NO_WRITE_IDLE_MODE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!load_mode_i && !busy) |=> !busy); // R9
endmodule

// File: tb/test_flash_word_dr.sv
module test_flash_word_dr;
  localparam int unsigned AW  = 6;
  localparam int unsigned LAT = 2;
  localparam logic [AW-1:0] P = 6'd4;
  localparam logic [7:0] LV [8] = '{8'h3C, 8'hA5, 8'h01, 8'hFE,
                                     8'h5A, 8'h80, 8'h7F, 8'hC3};

  logic tck = 1'b0;
  logic rst_ni = 1'b0;
  logic load_mode, read_mode, cap_dr, shift_dr, upd_dr, tdi;
  logic [AW-1:0] preset;
  logic tdo, fl_hi, fl_wr, fl_ack, busy, ovr;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_wdata;
  logic [15:0] fl_rdata;
  logic [15:0] mem [64];
  int unsigned ack_cnt;
  int n_chk = 0;
  int n_bad = 0;

  always #2 tck = ~tck;

  flash_word_dr #(.AW(AW)) i_flash_word_dr (
    .tck_i(tck), .rst_ni(rst_ni), .load_mode_i(load_mode), .read_mode_i(read_mode),
    .addr_preset_i(preset), .capture_dr_i(cap_dr), .shift_dr_i(shift_dr),
    .update_dr_i(upd_dr), .tdi_i(tdi), .tdo_o(tdo), .fl_addr_o(fl_addr),
    .fl_wdata_o(fl_wdata), .fl_hi_o(fl_hi), .fl_wr_o(fl_wr), .fl_ack_i(fl_ack),
    .fl_rdata_i(fl_rdata), .busy_o(busy), .ovr_o(ovr)
  );

  // page-buffer model: acks after LAT strobe cycles
  assign fl_rdata = mem[fl_addr];
  assign fl_ack   = fl_wr && (ack_cnt == LAT);
  always @(posedge tck) begin
    if (fl_wr) begin
      if (fl_ack) begin
        if (fl_hi) mem[fl_addr][15:8] <= fl_wdata;
        else       mem[fl_addr][7:0]  <= fl_wdata;
        ack_cnt <= 0;
      end else ack_cnt <= ack_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge tck); #1;
  endtask

  task automatic shift_in(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      shift_dr = 1'b1; tdi = b[i]; cyc();
    end
    shift_dr = 1'b0; tdi = 1'b0;
  endtask

  task automatic pulse_update();
    upd_dr = 1'b1; cyc(); upd_dr = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 100) begin n++; cyc(); end
  endtask

  task automatic load_byte(input logic [7:0] b, output int nb);
    shift_in(b);
    pulse_update();
    wait_idle(nb);
  endtask

  task automatic read_byte(output logic [7:0] b);
    cap_dr = 1'b1; cyc(); cap_dr = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge tck); #1;
      b[i] = tdo;
      shift_dr = 1'b1;
      @(posedge tck); #1;
    end
    shift_dr = 1'b0;
  endtask

  task automatic enter_mode(input logic ld, input logic rd, input logic [AW-1:0] a);
    load_mode = 1'b0; read_mode = 1'b0; cyc();
    preset = a; load_mode = ld; read_mode = rd; cyc();
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL R0 watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int nb;
    logic [7:0] rb;
    for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
    ack_cnt = 0;
    load_mode = 0; read_mode = 0; cap_dr = 0; shift_dr = 0; upd_dr = 0; tdi = 0;
    preset = '0;
    #9 rst_ni = 1'b1;
    cyc();
    // reset state
    check("R3 reset busy", busy, 0);
    check("R3 reset strobe", fl_wr, 0);
    check("R7 reset overrun", ovr, 0);
    check("R1 reset tdo", tdo, 0);
    check("R5 reset addr", fl_addr, 0);

    // table: one page load from P
    enter_mode(1'b1, 1'b0, P);
    for (int k = 0; k < 8; k++) begin
      load_byte(LV[k], nb);
      check("R4 lane data", (k % 2) ? mem[P + k/2][15:8] : mem[P + k/2][7:0], LV[k]);
      check("R5 word address", fl_addr, P + k/2);
      check("R6 busy window", (nb >= 2 && nb <= 11), 1);
    end
    check("R5 no step past page", fl_addr, P + 3);

    // table readback
    enter_mode(1'b0, 1'b1, P);
    for (int k = 0; k < 8; k++) begin
      read_byte(rb);
      check("R8 read byte", rb, LV[k]);
      check("R8 read address", fl_addr, P + (k + 1) / 2);
    end

    // re-entry with toggle left on high side
    enter_mode(1'b1, 1'b0, 6'd20);
    load_byte(8'h44, nb);
    enter_mode(1'b1, 1'b0, 6'd30);
    load_byte(8'h99, nb);
    check("R2 reentry low lane", mem[30][7:0], 8'h99);
    check("R2 reentry high untouched", mem[30][15:8], 8'h00);
    check("R2 reentry address", fl_addr, 30);

    // overrun: second update inside write window
    shift_in(8'h11);
    pulse_update();
    pulse_update();
    check("R7 overrun flag", ovr, 1);
    wait_idle(nb);
    check("R7 high lane written", mem[30][15:8], 8'h11);
    check("R7 next word untouched", mem[31], 16'h0000);
    check("R7 address held", fl_addr, 30);
    repeat (3) cyc();
    check("R7 overrun sticky", ovr, 1);

    // falling-edge output timing
    enter_mode(1'b0, 1'b1, 6'd30);
    check("R2 overrun cleared", ovr, 0);
    shift_in(8'h00);
    @(negedge tck); #1;
    check("R1 tdo flushed", tdo, 0);
    @(posedge tck); #1;
    cap_dr = 1'b1; cyc(); cap_dr = 1'b0;
    check("R1 tdo before fall", tdo, 0);
    @(negedge tck); #1;
    check("R1 tdo after fall", tdo, 1);
    shift_dr = 1'b1; @(posedge tck); #1; shift_dr = 1'b0;
    @(negedge tck); #1;
    check("R1 lsb first bit1", tdo, 0);
    @(posedge tck); #1;

    // no mode: update does nothing
    load_mode = 0; read_mode = 0; cyc();
    pulse_update();
    check("R9 no busy", busy, 0);
    cyc();
    check("R9 no strobe", fl_wr, 0);
    check("R9 memory intact", mem[31], 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule